// File: doc/BRIEF.md
# SPI Slave Memory Bus Bridge

This block is an SPI slave that turns each serial transaction into a run of parallel memory-style accesses. SCK, MOSI and the active-low select are brought into the system clock domain through two-flop synchronizers. SCK edges are found by comparing each synchronized SCK sample with the one before it. Clock polarity and clock phase are chosen at run time through two configuration inputs, so all four SPI modes are covered.

After the select falls, the first complete word is an address. It is placed on the parallel address bus, and a one-cycle read strobe fetches the word the master will receive next. Every later word travels in both directions at once. When a received word completes, it is presented on the write-data bus with a one-cycle write strobe. The address then steps by one, and a new read fetches the next outgoing word. Raising the select ends the transaction at any point and returns the block to the address phase.

Top module: `spi_mem_bridge`

## Requirements
- R1: `cfg_cpol` is the SCK idle level. With `cfg_cpha`=0, MOSI is sampled on the first edge of each bit (the edge leaving the idle level) and MISO moves on on the second edge. With `cfg_cpha`=1 the two edges swap roles.
- R2: Words are DW bits wide and travel MSB first on both lines. Each data word sent on MISO equals the memory content read for it.
- R3: The first complete word after the select falls is driven on `mem_addr`, and `mem_rd` is high in the same cycle, 3 clock cycles after the SCK pin edge that completes the word. `mem_rdata` is captured during that `mem_rd` cycle and becomes the next word sent.
- R4: `spi_miso` is 0 while the select is high and throughout the address word.
- R5: For the k-th data word after an address A, `mem_we` pulses 3 cycles after the completing SCK pin edge. During that pulse `mem_wdata` holds the received word and `mem_addr` equals A+k-1.
- R6: Two cycles after each `mem_we`, `mem_addr` has stepped by one (modulo 2^AW, so FF wraps to 00) and `mem_rd` pulses to fetch the next outgoing word.
- R7: `mem_rd` and `mem_we` are single-cycle pulses and are never high in the same cycle.
- R8: A high select aborts shifting. A partly received word, or a transaction holding only an address word, causes no write and no further address step. The next transaction starts again with an address word.
- R9: During and just after reset, `mem_rd`, `mem_we` and `spi_miso` are 0, and `mem_addr` and `mem_wdata` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | SCK idle level |
| cfg_cpha | input | 1 | 0: sample on the first edge of a bit, 1: sample on the second edge |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Active-low slave select |
| spi_miso | output | 1 | Serial data to the master |
| mem_addr | output | AW | Memory address |
| mem_rd | output | 1 | Read strobe |
| mem_rdata | input | DW | Read data, valid during the `mem_rd` cycle |
| mem_we | output | 1 | Write strobe |
| mem_wdata | output | DW | Write data |

## Verification
The assertions take for granted that SCK holds each level for at least two system clocks, so no two edge events fall in consecutive cycles. They also assume each half period is long enough for the write, step and fetch sequence to finish before the next sampling edge, and that the configuration inputs stay constant while the select is low. The stimulus keeps within these limits. Its master holds each SCK half period for eight system clocks and changes polarity and phase only while the select is high. It waits two half periods before raising the select, and keeps the select high for several half periods between transactions. Under these conditions every load into the transmit register lands between words, and the read data is valid in the cycle it is strobed.

// File: rtl/spimb_pkg.sv
package spimb_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_WRITE = 2'd1,
    SEQ_STEP  = 2'd2,
    SEQ_FETCH = 2'd3
  } seq_state_t;

  typedef struct packed {
    logic sample;
    logic shift;
  } sck_evt_t;

endpackage

// File: rtl/spimb_sync.sv
module spimb_sync #(
  parameter int           W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_bit
      logic meta_q;
      logic stab_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= RST_VAL[i];
          stab_q <= RST_VAL[i];
        end else begin
          meta_q <= d_async[i];
          stab_q <= meta_q;
        end
      end

      assign q_sync[i] = stab_q;
    end
  endgenerate

endmodule

// File: rtl/spimb_edge.sv
module spimb_edge
  import spimb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sck_s,
  input  logic     cpol,
  input  logic     cpha,
  output sck_evt_t evt
);

  logic sck_prev_q;
  logic sck_prev_n;
  logic toggled;
  logic leading;
  logic trailing;

  always_comb begin
    sck_prev_n = sck_s;
    toggled    = sck_s ^ sck_prev_q;
    leading    = toggled & (sck_s != cpol);
    trailing   = toggled & (sck_s == cpol);
    evt.sample = cpha ? trailing : leading;
    evt.shift  = cpha ? leading  : trailing;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= sck_prev_n;
  end

  AST_SCK_RATE: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.sample || evt.shift) |=> !(evt.sample || evt.shift)); // R1

endmodule

// File: rtl/spimb_shift.sv
module spimb_shift #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          mosi_s,
  input  logic          sample,
  input  logic          shift,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  output logic          miso,
  output logic          word_done,
  output logic [DW-1:0] word
);

  localparam int             CW   = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0]  LAST = CW'(DW - 1);

  logic [CW-1:0] bit_cnt_q, bit_cnt_n;
  logic [DW-2:0] rx_sr_q,   rx_sr_n;
  logic [DW-1:0] tx_sr_q,   tx_sr_n;
  logic          cnt_en, rx_en, tx_en;

  always_comb begin
    word      = {rx_sr_q, mosi_s};
    word_done = active & sample & (bit_cnt_q == LAST);

    bit_cnt_n = bit_cnt_q;
    rx_sr_n   = rx_sr_q;
    tx_sr_n   = tx_sr_q;
    cnt_en    = 1'b0;
    rx_en     = 1'b0;
    tx_en     = 1'b0;

    if (!active) begin
      bit_cnt_n = '0;
      rx_sr_n   = '0;
      tx_sr_n   = '0;
      cnt_en    = 1'b1;
      rx_en     = 1'b1;
      tx_en     = 1'b1;
    end else begin
      if (sample) begin
        rx_sr_n   = word[DW-2:0];
        bit_cnt_n = (bit_cnt_q == LAST) ? '0 : bit_cnt_q + 1'b1;
        cnt_en    = 1'b1;
        rx_en     = 1'b1;
      end
      if (load) begin
        tx_sr_n = load_data;
        tx_en   = 1'b1;
      end else if (shift && (bit_cnt_q != '0)) begin
        tx_sr_n = {tx_sr_q[DW-2:0], 1'b0};
        tx_en   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      rx_sr_q   <= '0;
      tx_sr_q   <= '0;
    end else begin
      if (cnt_en) bit_cnt_q <= bit_cnt_n;
      if (rx_en)  rx_sr_q   <= rx_sr_n;
      if (tx_en)  tx_sr_q   <= tx_sr_n;
    end
  end

  assign miso = tx_sr_q[DW-1];

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !miso); // R4

  AST_LOAD_BETWEEN_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (bit_cnt_q == '0)); // R3

endmodule

// File: rtl/spimb_seq.sv
module spimb_seq
  import spimb_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          word_done,
  input  logic [DW-1:0] word,
  input  logic [DW-1:0] rdata,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata,
  output logic          rd,
  output logic          we,
  output logic          load,
  output logic [DW-1:0] load_data
);

  localparam logic [AW-1:0] ADDR_ONE = AW'(1);

  seq_state_t    state_q, state_n;
  logic          in_data_q, in_data_n;
  logic [AW-1:0] addr_q, addr_n;
  logic [DW-1:0] wdata_q, wdata_n;
  logic          addr_en, wdata_en;

  always_comb begin
    state_n   = state_q;
    in_data_n = in_data_q;
    addr_n    = addr_q;
    wdata_n   = wdata_q;
    addr_en   = 1'b0;
    wdata_en  = 1'b0;

    case (state_q)
      SEQ_IDLE: begin
        if (word_done) begin
          if (!in_data_q) begin
            addr_n    = AW'(word);
            addr_en   = 1'b1;
            in_data_n = 1'b1;
            state_n   = SEQ_FETCH;
          end else begin
            wdata_n  = word;
            wdata_en = 1'b1;
            state_n  = SEQ_WRITE;
          end
        end
      end
      SEQ_WRITE: state_n = SEQ_STEP;
      SEQ_STEP: begin
        addr_n  = addr_q + ADDR_ONE;
        addr_en = 1'b1;
        state_n = SEQ_FETCH;
      end
      SEQ_FETCH: state_n = SEQ_IDLE;
      default:   state_n = SEQ_IDLE;
    endcase

    if (!active) in_data_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= SEQ_IDLE;
      in_data_q <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else begin
      state_q   <= state_n;
      in_data_q <= in_data_n;
      if (addr_en)  addr_q  <= addr_n;
      if (wdata_en) wdata_q <= wdata_n;
    end
  end

  always_comb begin
    addr      = addr_q;
    wdata     = wdata_q;
    rd        = (state_q == SEQ_FETCH);
    we        = (state_q == SEQ_WRITE);
    load      = rd;
    load_data = rdata;
  end

  AST_WORD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (state_q == SEQ_IDLE)); // R3

  AST_ADDR_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !in_data_q) |=> (rd && (addr == AW'($past(word))))); // R3

  AST_WDATA_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && in_data_q) |=> (we && (wdata == $past(word)))); // R5

  AST_WE_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (addr == $past(addr))); // R5

  AST_STEP_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ##2 (rd && (addr == $past(addr, 2) + ADDR_ONE))); // R6

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd |=> !rd); // R7

  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> !we); // R7

endmodule

// File: rtl/spi_mem_bridge.sv
module spi_mem_bridge
  import spimb_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cpol,
  input  logic          cfg_cpha,
  input  logic          spi_sck,
  input  logic          spi_mosi,
  input  logic          spi_ss_n,
  output logic          spi_miso,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] mem_wdata
);

  localparam int NSYNC = 3;

  logic [1:0]       rst_pipe_q;
  logic             rst_s_n;
  logic [NSYNC-1:0] pins_s;
  logic             ss_n_s, sck_s, mosi_s;
  logic             active;
  sck_evt_t         evt;
  logic             word_done;
  logic [DW-1:0]    word;
  logic             load;
  logic [DW-1:0]    load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  spimb_sync #(.W(NSYNC), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .d_async ({spi_ss_n, spi_sck, spi_mosi}),
    .q_sync  (pins_s)
  );

  assign ss_n_s = pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];
  assign active = ~ss_n_s;

  spimb_edge u_edge (
    .clk   (clk),
    .rst_n (rst_s_n),
    .sck_s (sck_s),
    .cpol  (cfg_cpol),
    .cpha  (cfg_cpha),
    .evt   (evt)
  );

  spimb_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .active    (active),
    .mosi_s    (mosi_s),
    .sample    (evt.sample),
    .shift     (evt.shift),
    .load      (load),
    .load_data (load_data),
    .miso      (spi_miso),
    .word_done (word_done),
    .word      (word)
  );

  spimb_seq #(.DW(DW), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .active    (active),
    .word_done (word_done),
    .word      (word),
    .rdata     (mem_rdata),
    .addr      (mem_addr),
    .wdata     (mem_wdata),
    .rd        (mem_rd),
    .we        (mem_we),
    .load      (load),
    .load_data (load_data)
  );

  AST_RD_WE_EXCL: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(mem_rd && mem_we)); // R7

  AST_CFG_STEADY: assert property (@(posedge clk) disable iff (!rst_s_n)
    (active && $past(active)) |-> ($stable(cfg_cpol) && $stable(cfg_cpha))); // R1

endmodule

// File: tb/spi_mem_bridge_tb_top.sv
module spi_mem_bridge_tb_top;

  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n;
  logic          cfg_cpol, cfg_cpha;
  logic          spi_sck, spi_mosi, spi_ss_n;
  logic          spi_miso;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_we;
  logic [DW-1:0] mem_rdata, mem_wdata;

  spi_mem_bridge #(.DW(DW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_ss_n(spi_ss_n),
    .spi_miso(spi_miso), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  logic [7:0] mem     [0:255];
  logic [7:0] ref_mem [0:255];
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  typedef struct {
    bit         is_wr;
    logic [7:0] a;
    logic [7:0] d;
    int         ofs;
  } ev_t;

  ev_t exp_q[$];
  int  n_cmp = 0;
  int  n_bad = 0;
  int  cyc   = 0;
  int  edge_cyc = 0;
  int  ss_hi = 0;
  bit  done = 0;
  bit  prev_rd = 0, prev_we = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference monitor: compares strobes against the expected event list each clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd && mem_we) check("R7", "rd and we together", 1, 0);
      if (mem_rd && prev_rd) check("R7", "rd longer than one cycle", 1, 0);
      if (mem_we && prev_we) check("R7", "we longer than one cycle", 1, 0);
      if (mem_we || mem_rd) begin
        if (exp_q.size() == 0) begin
          check("R8", "unexpected strobe", 1, 0);
        end else begin
          ev_t e;
          e = exp_q.pop_front();
          check(e.is_wr ? "R5" : "R3", "strobe kind is write", int'(mem_we), int'(e.is_wr));
          check(e.is_wr ? "R5" : "R6", "strobe address", mem_addr, e.a);
          check(e.ofs == 5 ? "R6" : "R3", "strobe latency", cyc - edge_cyc, e.ofs);
          if (e.is_wr) check("R5", "write data", mem_wdata, e.d);
        end
      end
      prev_rd = mem_rd;
      prev_we = mem_we;
      if (spi_ss_n) ss_hi++; else ss_hi = 0;
      if (ss_hi == 6) check("R4", "miso while select high", spi_miso, 0);
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_txn(input bit cpol, input bit cpha, input logic [7:0] a,
                         input int nwr, input int partial);
    int nwords;
    nwords = 1 + nwr + ((partial > 0) ? 1 : 0);
    cfg_cpol = cpol;
    cfg_cpha = cpha;
    spi_sck  = cpol;
    wait_n(2 * HALF);
    spi_ss_n = 1'b0;
    for (int w = 0; w < nwords; w++) begin
      logic [7:0] out_w, exp_tx, got;
      int nb;
      bit full;
      full   = (w <= nwr);
      nb     = full ? 8 : partial;
      out_w  = (w == 0) ? a : (8'hC6 ^ a ^ 8'(w * 59));
      exp_tx = (w == 0) ? 8'h00 : ref_mem[8'(a + 8'(w - 1))];
      got    = 8'h00;
      if (full) begin
        ev_t e;
        if (w == 0) begin
          e.is_wr = 0; e.a = a; e.d = 0; e.ofs = 3; exp_q.push_back(e);
        end else begin
          e.is_wr = 1; e.a = 8'(a + 8'(w - 1)); e.d = out_w; e.ofs = 3; exp_q.push_back(e);
          e.is_wr = 0; e.a = 8'(a + 8'(w));     e.d = 0;     e.ofs = 5; exp_q.push_back(e);
        end
      end
      for (int b = 0; b < nb; b++) begin
        if (!cpha) begin
          spi_mosi = out_w[7-b];
          wait_n(HALF);
          got[7-b] = spi_miso;
          if (b == 7) edge_cyc = cyc;
          spi_sck = ~spi_sck;
          wait_n(HALF);
          spi_sck = ~spi_sck;
        end else begin
          spi_sck  = ~spi_sck;
          spi_mosi = out_w[7-b];
          wait_n(HALF);
          got[7-b] = spi_miso;
          if (b == 7) edge_cyc = cyc;
          spi_sck = ~spi_sck;
          wait_n(HALF);
        end
      end
      if (full) begin
        if (w == 0) check("R4", "miso during address word", got, 0);
        else        check("R2", "word sent on miso", got, exp_tx);
        if (w > 0) ref_mem[8'(a + 8'(w - 1))] = out_w;
      end
    end
    wait_n(2 * HALF);
    spi_ss_n = 1'b1;
    wait_n(3 * HALF);
    check("R8", "pending strobes at transaction end", exp_q.size(), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      mem[i]     = 8'(i * 13 + 5);
      ref_mem[i] = 8'(i * 13 + 5);
    end
    rst_n = 1'b0; cfg_cpol = 1'b0; cfg_cpha = 1'b0;
    spi_sck = 1'b0; spi_mosi = 1'b0; spi_ss_n = 1'b1;
    wait_n(4);
    check("R9", "reset mem_rd", mem_rd, 0);
    check("R9", "reset mem_we", mem_we, 0);
    check("R9", "reset miso", spi_miso, 0);
    rst_n = 1'b1;
    wait_n(3);
    check("R9", "post-reset mem_addr", mem_addr, 0);
    check("R9", "post-reset mem_wdata", mem_wdata, 0);
    check("R9", "post-reset strobes", int'(mem_rd | mem_we), 0);
    wait_n(4);

    run_txn(1'b0, 1'b0, 8'h10, 3, 0);   // R1 mode 0
    run_txn(1'b0, 1'b1, 8'h40, 2, 0);   // R1 mode 1
    run_txn(1'b1, 1'b0, 8'h80, 2, 0);   // R1 mode 2
    run_txn(1'b1, 1'b1, 8'hFE, 3, 0);   // R6 wrap FF -> 00, mode 3
    run_txn(1'b0, 1'b0, 8'h55, 0, 0);   // R8 address-only transaction
    run_txn(1'b1, 1'b1, 8'h20, 1, 5);   // R8 abort mid-word
    run_txn(1'b1, 1'b1, 8'h21, 1, 0);   // R8 next starts in address phase
    run_txn(1'b0, 1'b1, 8'h10, 3, 0);   // R5 read back earlier writes
    run_txn(1'b1, 1'b0, 8'hFF, 2, 0);   // R2 R6 wrapped read back

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule